// File: doc/BRIEF.md
# Complementary PWM Pair with Trough-Window Clear Suppression

This block generates one complementary PWM pair from a triangular carrier. A lower counter sweeps up from zero to a programmed peak and back down. An upper counter runs in lockstep with it, offset by a dead-time value. The positive phase is active while the lower counter is above a compare value. The negative phase is active while the upper counter is below that compare value. Because of the offset, a band of dead time separates the two phases on every edge.

An external synchronous clear restarts both counters. A clear normally puts the pair back into its initial state, with both phases inactive until the next crest. When the suppression-enable bit is set and the clear lands while the lower counter is below the dead-time value (the trough window), the counters restart but the outputs keep following the compare result. This prevents an abrupt jump in duty cycle. A clear that lands in the initial period straight after a start is always forced, even if it falls in the trough window.

Configuration is written through a small register port into shadow copies. The working copies are loaded only at a start, at a clear, or when the carrier reaches its trough.

Top module: `cpwm_pair`

## Requirements
- R1: After reset both outputs sit at the inactive level of the default setting (logic 1, since the default level select is active-low), and the counters stay idle until a start.
- R2: A start pulse restarts the lower counter at 0, counting up. The counter climbs by one per cycle to the peak value, then falls by one per cycle back to 0. The peak register (address 0) holds at least 2; a written value below 2 is stored as 2.
- R3: While running, the upper counter always equals the lower counter plus the working dead-time value (address 1).
- R4: The positive phase is active when lower > compare (address 2). The negative phase is active when upper < compare. Control bit 0 (address 3) selects the active level: 1 means active-high, 0 means active-low. Inactive is the opposite level.
- R5: The two phases are never active in the same cycle.
- R6: From a start until the cycle after the first crest (the lower counter at the peak while counting up), both phases are held inactive.
- R7: A clear accepted outside the trough window restarts both counters and re-enters the initial period of R6, whatever the value of the suppression bit.
- R8: With suppression enabled (control bit 1 = 1), a clear accepted while the lower counter is below the dead-time value, and outside the initial period, restarts both counters without forcing the outputs inactive.
- R9: A clear that falls inside the initial period is always forced, even with suppression enabled and the counter in the trough window.
- R10: With suppression disabled, every accepted clear is forced.
- R11: Register writes go to shadow copies. These are loaded into the working set on a start, on an accepted clear, or on the cycle the descending lower counter reaches 0. A write in the same cycle as a load takes effect at the following load. While the counters are idle, writes do not change the outputs.
- R12: A start and a clear in the same cycle act as a start; a clear is ignored while the counters are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 peak, 1 dead time, 2 compare, 3 control |
| wr_data_i | input | CNT_W | Write data; for control, bit 0 is level select and bit 1 is suppression enable |
| start_i | input | 1 | Start and restart pulse |
| sync_clr_i | input | 1 | Synchronous counter clear pulse |
| pos_o | output | 1 | Positive-phase output |
| neg_o | output | 1 | Negative-phase output |

## Verification
The clear and the trough reload can land in the same cycle. This happens when the descending counter steps from 1 to 0 while the clear is raised. The bench provokes that collision on purpose and expects the clear's restart to win, with one load, no forcing when suppression applies, and the upper counter re-based to the new dead time. The bench also drives a start together with a clear, and a register write in the cycle of a trough load. The behavioural model of the bench predicts every output on every clock, so any disagreement shows up in the very cycle it occurs.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    ADDR_PEAK = 2'd0,
    ADDR_DEAD = 2'd1,
    ADDR_CMP  = 2'd2,
    ADDR_CTL  = 2'd3
  } reg_addr_e;

  localparam int unsigned CTL_LVL = 0;
  localparam int unsigned CTL_SUP = 1;
  localparam int unsigned MIN_PEAK = 2;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_PEAK = 8,
  parameter logic [CNT_W-1:0] RST_DEAD = 2,
  parameter logic [CNT_W-1:0] RST_CMP  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] peak_o,
  output logic [CNT_W-1:0] dead_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             lvl_o,
  output logic             sup_o,
  output logic [CNT_W-1:0] dead_shd_o
);
  localparam logic [CNT_W-1:0] PEAK_MIN = CNT_W'(MIN_PEAK);

  logic [CNT_W-1:0] peak_s, dead_s, cmp_s;
  logic             lvl_s, sup_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_s <= RST_PEAK;
      dead_s <= RST_DEAD;
      cmp_s  <= RST_CMP;
      lvl_s  <= 1'b0;
      sup_s  <= 1'b0;
    end else if (wr_en_i) begin
      unique case (reg_addr_e'(wr_addr_i))
        ADDR_PEAK: peak_s <= (wr_data_i < PEAK_MIN) ? PEAK_MIN : wr_data_i;
        ADDR_DEAD: dead_s <= wr_data_i;
        ADDR_CMP:  cmp_s  <= wr_data_i;
        ADDR_CTL: begin
          lvl_s <= wr_data_i[CTL_LVL];
          sup_s <= wr_data_i[CTL_SUP];
        end
      endcase
    end
  end

  // working copy only moves at a load point
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_o <= RST_PEAK;
      dead_o <= RST_DEAD;
      cmp_o  <= RST_CMP;
      lvl_o  <= 1'b0;
      sup_o  <= 1'b0;
    end else if (load_i) begin
      peak_o <= peak_s;
      dead_o <= dead_s;
      cmp_o  <= cmp_s;
      lvl_o  <= lvl_s;
      sup_o  <= sup_s;
    end
  end

  assign dead_shd_o = dead_s;
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned HI_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] peak_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] dead_shd_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [HI_W-1:0]  hi_o,
  output logic             up_o,
  output logic             crest_o,
  output logic             trough_ld_o,
  output logic             tb_o
);
  localparam logic [CNT_W-1:0] LO_ONE = CNT_W'(1);
  localparam logic [HI_W-1:0]  HI_ONE = HI_W'(1);

  logic [CNT_W-1:0] lo_q, lo_d, dead_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic             up_q, up_d, tb_q;

  assign crest_o     = run_i && !restart_i && up_q && (lo_q >= peak_i);
  assign trough_ld_o = run_i && !restart_i && !up_q && (lo_q == LO_ONE);

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    up_d = up_q;
    if (restart_i) begin
      lo_d = '0;
      hi_d = {1'b0, dead_shd_i};
      up_d = 1'b1;
    end else if (run_i) begin
      if (up_q) begin
        if (lo_q < peak_i) begin
          lo_d = lo_q + LO_ONE;
          hi_d = hi_q + HI_ONE;
        end else begin
          up_d = 1'b0;
          lo_d = lo_q - LO_ONE;
          hi_d = hi_q - HI_ONE;
        end
      end else if (lo_q == '0) begin
        up_d = 1'b1;
        lo_d = LO_ONE;
        hi_d = hi_q + HI_ONE;
      end else begin
        lo_d = lo_q - LO_ONE;
        hi_d = trough_ld_o ? {1'b0, dead_shd_i} : hi_q - HI_ONE;
      end
    end
    dead_d = (restart_i || trough_ld_o) ? dead_shd_i : dead_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
      up_q <= 1'b1;
      tb_q <= 1'b0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      up_q <= up_d;
      tb_q <= lo_d < dead_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
  assign up_o = up_q;
  assign tb_o = tb_q;
endmodule

// File: rtl/cpwm_ctrl.sv
module cpwm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clr_i,
  input  logic tb_i,
  input  logic crest_i,
  input  logic sup_i,
  output logic run_o,
  output logic init_o,
  output logic restart_o,
  output logic clr_acc_o,
  output logic supp_o
);
  logic run_q, init_q;

  assign clr_acc_o = clr_i && run_q && !start_i;
  assign supp_o    = clr_acc_o && sup_i && tb_i && !init_q;
  assign restart_o = start_i || clr_acc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      init_q <= 1'b0;
    end else begin
      run_q <= run_q || start_i;
      if (start_i)                    init_q <= 1'b1;
      else if (clr_acc_o && !supp_o)  init_q <= 1'b1;
      else if (crest_i)               init_q <= 1'b0;
    end
  end

  assign run_o  = run_q;
  assign init_o = init_q;
endmodule

// File: rtl/cpwm_outgen.sv
module cpwm_outgen #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned HI_W = CNT_W + 1
) (
  input  logic             run_i,
  input  logic             init_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [HI_W-1:0]  hi_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             lvl_i,
  output logic             pos_o,
  output logic             neg_o
);
  logic quiet, pos_act, neg_act;

  assign quiet   = !run_i || init_i;
  assign pos_act = !quiet && (lo_i > cmp_i);
  assign neg_act = !quiet && (hi_i < {1'b0, cmp_i});
  assign pos_o   = pos_act ? lvl_i : !lvl_i;
  assign neg_o   = neg_act ? lvl_i : !lvl_i;
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair #(
  parameter int unsigned CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_PEAK = 8,
  parameter logic [CNT_W-1:0] RST_DEAD = 2,
  parameter logic [CNT_W-1:0] RST_CMP  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             start_i,
  input  logic             sync_clr_i,
  output logic             pos_o,
  output logic             neg_o
);
  localparam int unsigned HI_W = CNT_W + 1;

  logic [CNT_W-1:0] peak_a, dead_a, cmp_a, dead_shd, lo;
  logic [HI_W-1:0]  hi;
  logic lvl_a, sup_a, up, crest, trough_ld, tb;
  logic run, init, restart, clr_acc, supp, load;

  assign load = restart || trough_ld;

  cpwm_regs #(
    .CNT_W(CNT_W), .RST_PEAK(RST_PEAK), .RST_DEAD(RST_DEAD), .RST_CMP(RST_CMP)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(load), .peak_o(peak_a), .dead_o(dead_a), .cmp_o(cmp_a),
    .lvl_o(lvl_a), .sup_o(sup_a), .dead_shd_o(dead_shd)
  );

  cpwm_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .clr_i(sync_clr_i), .tb_i(tb), .crest_i(crest),
    .sup_i(sup_a), .run_o(run), .init_o(init), .restart_o(restart),
    .clr_acc_o(clr_acc), .supp_o(supp)
  );

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .restart_i(restart), .peak_i(peak_a),
    .dead_i(dead_a), .dead_shd_i(dead_shd), .lo_o(lo), .hi_o(hi), .up_o(up),
    .crest_o(crest), .trough_ld_o(trough_ld), .tb_o(tb)
  );

  cpwm_outgen #(.CNT_W(CNT_W)) u_out (
    .run_i(run), .init_i(init), .lo_i(lo), .hi_i(hi), .cmp_i(cmp_a),
    .lvl_i(lvl_a), .pos_o, .neg_o
  );
endmodule

// File: rtl/cpwm_pair_sva.sv
module cpwm_pair_sva #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             sync_clr_i,
  input logic             run_i,
  input logic             init_i,
  input logic             clr_acc_i,
  input logic             supp_i,
  input logic             up_i,
  input logic [CNT_W-1:0] lo_i,
  input logic [CNT_W:0]   hi_i,
  input logic [CNT_W-1:0] peak_i,
  input logic [CNT_W-1:0] dead_i,
  input logic             lvl_i,
  input logic             pos_i,
  input logic             neg_i
);
  AST_NO_DUAL_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((pos_i == lvl_i) && (neg_i == lvl_i))); // R5
  AST_START_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (lo_i == '0) && up_i && init_i); // R2
  AST_LO_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> lo_i <= peak_i); // R2
  AST_HI_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> hi_i == ({1'b0, lo_i} + {1'b0, dead_i})); // R3
  AST_FORCED_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_acc_i && !supp_i) |=> init_i && (lo_i == '0)); // R7
  AST_KEPT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supp_i |=> !init_i && (lo_i == '0) && up_i); // R8
  AST_SUPP_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supp_i |-> lo_i < dead_i); // R8
  AST_START_OVER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sync_clr_i) |=> init_i); // R12
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> !run_i); // R12
endmodule

bind cpwm_pair cpwm_pair_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sync_clr_i(sync_clr_i),
  .run_i(run), .init_i(init), .clr_acc_i(clr_acc), .supp_i(supp), .up_i(up),
  .lo_i(lo), .hi_i(hi), .peak_i(peak_a), .dead_i(dead_a), .lvl_i(lvl_a),
  .pos_i(pos_o), .neg_i(neg_o)
);

// File: tb/cpwm_pair_tb.sv
module cpwm_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        start = 1'b0;
  logic        clr = 1'b0;
  logic        pos, neg;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";

  // reference state
  int m_run = 0, m_lo = 0, m_up = 1, m_init = 0;
  int m_peak = 8, m_dead = 2, m_cmp = 4, m_lvl = 0, m_sup = 0;
  int s_peak = 8, s_dead = 2, s_cmp = 4, s_lvl = 0, s_sup = 0;

  always #10 clk = ~clk;

  cpwm_pair dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .sync_clr_i(clr),
    .pos_o(pos), .neg_o(neg)
  );

  task automatic load_work();
    m_peak = s_peak; m_dead = s_dead; m_cmp = s_cmp; m_lvl = s_lvl; m_sup = s_sup;
  endtask

  task automatic model_step(input bit st, input bit cl, input bit we,
                            input int ad, input int d);
    bit in_win;
    bit kept;
    in_win = (m_lo < m_dead);
    if (st) begin
      m_run = 1; m_lo = 0; m_up = 1; m_init = 1; load_work();
    end else if (cl && m_run != 0) begin
      kept = (m_sup != 0) && in_win && (m_init == 0);
      m_lo = 0; m_up = 1; load_work();
      if (!kept) m_init = 1;
    end else if (m_run != 0) begin
      if (m_up != 0) begin
        if (m_lo < m_peak) m_lo++;
        else begin m_up = 0; m_lo--; m_init = 0; end
      end else if (m_lo == 0) begin
        m_up = 1; m_lo = 1;
      end else begin
        m_lo--;
        if (m_lo == 0) load_work();
      end
    end
    if (we) begin
      case (ad)
        0: s_peak = (d < 2) ? 2 : d;
        1: s_dead = d;
        2: s_cmp  = d;
        default: begin s_lvl = d & 1; s_sup = (d >> 1) & 1; end
      endcase
    end
  endtask

  task automatic compare();
    bit quiet, pa, na, ep, en;
    quiet = (m_run == 0) || (m_init != 0);
    pa = !quiet && (m_lo > m_cmp);
    na = !quiet && ((m_lo + m_dead) < m_cmp);
    ep = pa ? m_lvl[0] : !m_lvl[0];
    en = na ? m_lvl[0] : !m_lvl[0];
    vectors++;
    if (pos !== ep || neg !== en) begin
      fails++;
      $display("FAIL %s: pos,neg = %b,%b expected %b,%b (lo=%0d)", cur_req, pos, neg, ep, en, m_lo);
    end
  endtask

  task automatic cyc(input bit st, input bit cl, input bit we, input int ad, input int d);
    start = st; clr = cl; wr_en = we; wr_addr = ad[1:0]; wr_data = d[15:0];
    @(posedge clk);
    model_step(st, cl, we, ad, d);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int ad, input int d);
    cyc(0, 0, 1, ad, d);
  endtask

  // advance until the carrier descends inside the trough window, out of the initial period
  task automatic to_trough(input int lo_want);
    for (int i = 0; i < 500; i++) begin
      if (m_run != 0 && m_up == 0 && m_lo == lo_want && m_init == 0) break;
      cyc(0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    cur_req = "R1";  idle(4);
    cur_req = "R11";
    wr(0, 10); wr(1, 3); wr(2, 6); wr(3, 2);
    idle(3);
    cur_req = "R6";  cyc(1, 0, 0, 0, 0); idle(14);
    cur_req = "R4";  idle(40);
    cur_req = "R7";
    for (int i = 0; i < 40; i++) begin
      if (m_up != 0 && m_lo == m_peak - 2 && m_init == 0) break;
      cyc(0, 0, 0, 0, 0);
    end
    cyc(0, 1, 0, 0, 0); idle(25);
    cur_req = "R8";  to_trough(2); cyc(0, 1, 0, 0, 0); idle(30);
    cur_req = "R9";  cyc(1, 0, 0, 0, 0); idle(1); cyc(0, 1, 0, 0, 0); idle(30);
    cur_req = "R11"; wr(2, 8); idle(30);
    to_trough(1); wr(2, 5); idle(30);
    cur_req = "R8";  to_trough(1); cyc(0, 1, 0, 0, 0); idle(30);
    cur_req = "R10"; wr(3, 0); idle(25); to_trough(2); cyc(0, 1, 0, 0, 0); idle(30);
    cur_req = "R12"; wr(3, 3); cyc(1, 1, 0, 0, 0); idle(30);
    cur_req = "R4";  idle(30);
    cur_req = "R3";  wr(1, 5); wr(2, 7); cyc(1, 0, 0, 0, 0); idle(50);
    cur_req = "R8";  to_trough(3); cyc(0, 1, 0, 0, 0); idle(30);
    cur_req = "R2";  wr(0, 0); wr(1, 1); wr(2, 1); cyc(1, 0, 0, 0, 0); idle(20);
    wr(0, 12); idle(40);
    cur_req = "R5";  wr(1, 0); wr(2, 4); idle(40);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule